// File: doc/BRIEF.md
# Hybrid Dynamic-Static Branch Direction Predictor

This block predicts the direction of conditional branches for an in-order fetch stage. It keeps a direct-mapped history table. Each slot holds a valid flag, a tag taken from the upper bits of the branch address, and a 2-bit saturating confidence counter. The slot is chosen by the word-address bits just above the byte offset.

When a lookup finds a matching slot, the counter's upper bit gives the direction. When it does not, a fixed rule based on the displacement sign decides. A branch that jumps back to a lower address is guessed taken. One that jumps forward, or by zero, is guessed not taken. Every lookup also yields the target address, which is the branch address plus the sign-extended displacement. All three results appear on registered outputs one cycle after the request.

The execute stage reports each resolved branch on a separate port, giving its word address and its real outcome. A resolution that misses the table claims the slot and seeds its counter. A resolution that hits moves the counter one step toward the outcome.

Top module: `bhp_hybrid`

## Requirements
- R1: A synchronous reset empties the table and drives `pr_valid`, `pr_hit` and `pr_taken` low; every lookup made before the first resolution afterwards reports `pr_hit` = 0.
- R2: `pr_valid` in a cycle equals `lk_valid` in the previous cycle; while `pr_valid` is 0, `pr_hit` and `pr_taken` are 0.
- R3: One cycle after a lookup, `pr_target` equals `lk_pc` plus `lk_disp` sign-extended to the address width, modulo 2^ADDR_W.
- R4: On a lookup that misses, a negative displacement (MSB of `lk_disp` = 1) gives `pr_taken` = 1 and `pr_hit` = 0.
- R5: On a lookup that misses, a zero or positive displacement gives `pr_taken` = 0 and `pr_hit` = 0.
- R6: A resolution that misses writes the slot at index `pc[IDX_W+1:2]`. The slot is marked valid and given tag `pc[ADDR_W-1:IDX_W+2]`. Its counter is set to 2 if the branch was taken and to 1 if it was not.
- R7: A lookup whose index slot is valid with an equal tag reports `pr_hit` = 1, and `pr_taken` is bit 1 of that slot's counter, whatever the displacement.
- R8: A resolution that hits adds 1 to the counter when taken and subtracts 1 when not taken, holding at 3 and at 0.
- R9: A resolution whose tag differs from the one stored at its index replaces that slot as in R6. The old branch then misses.
- R10: When a lookup and a resolution share a cycle, the lookup sees the table as it stood before that resolution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request for a conditional branch |
| lk_pc | input | ADDR_W | Byte address of the branch being looked up |
| lk_disp | input | DISP_W | Signed byte displacement of the branch |
| rs_valid | input | 1 | A resolved branch is reported this cycle |
| rs_pc | input | ADDR_W-2 | Word address (byte address bits ADDR_W-1:2) of the resolved branch |
| rs_taken | input | 1 | Real outcome of the resolved branch |
| pr_valid | output | 1 | Prediction outputs hold a result |
| pr_taken | output | 1 | Predicted direction |
| pr_hit | output | 1 | Prediction came from the history table |
| pr_target | output | ADDR_W | Predicted target address |

## Verification
Right after reset, every one of the 64 slots is looked up with negative, zero and positive displacements, including the two extreme values and an address that wraps. This separates the static rule from the table and shows the target sum. Each slot then receives several tags, each with a different taken/not-taken sequence. A lookup follows every resolution and is compared with an arithmetic counter model, which tells seeding apart from stepping, saturation from wrap, and tag aliasing from a true hit. Explicit runs drive a counter into both rails. A lookup issued in the same cycle as a resolution of the same branch must show the table's prior state.

// File: rtl/bhp_hybrid.sv
module bhp_hybrid #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6,
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_pc,
  input  logic [DISP_W-1:0] lk_disp,
  input  logic              rs_valid,
  input  logic [ADDR_W-1:2] rs_pc,
  input  logic              rs_taken,
  output logic              pr_valid,
  output logic              pr_taken,
  output logic              pr_hit,
  output logic [ADDR_W-1:0] pr_target
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = ADDR_W - IDX_W - 2;

  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [1:0]         ctr_q [ENTRIES];

  logic [IDX_W-1:0] lk_idx, rs_idx;
  logic [TAG_W-1:0] lk_tag, rs_tag;
  logic             lk_hit, lk_dir, rs_hit;
  logic [1:0]       rs_cur, rs_nxt;
  logic [ADDR_W-1:0] lk_tgt;

  assign lk_idx = lk_pc[IDX_W+1:2];
  assign lk_tag = lk_pc[ADDR_W-1:IDX_W+2];
  assign lk_hit = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_dir = lk_hit ? ctr_q[lk_idx][1] : lk_disp[DISP_W-1];
  assign lk_tgt = lk_pc + {{(ADDR_W-DISP_W){lk_disp[DISP_W-1]}}, lk_disp};

  assign rs_idx = rs_pc[IDX_W+1:2];
  assign rs_tag = rs_pc[ADDR_W-1:IDX_W+2];
  assign rs_hit = vld_q[rs_idx] && (tag_q[rs_idx] == rs_tag);
  assign rs_cur = ctr_q[rs_idx];

  always_comb begin
    if (!rs_hit)
      rs_nxt = rs_taken ? 2'b10 : 2'b01;
    else if (rs_taken)
      rs_nxt = (rs_cur == 2'b11) ? 2'b11 : rs_cur + 2'b01;
    else
      rs_nxt = (rs_cur == 2'b00) ? 2'b00 : rs_cur - 2'b01;
  end

  always_ff @(posedge clk) begin
    if (rst)
      vld_q <= '0;
    else if (rs_valid)
      vld_q[rs_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst && rs_valid) begin
      tag_q[rs_idx] <= rs_tag;
      ctr_q[rs_idx] <= rs_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pr_valid  <= 1'b0;
      pr_taken  <= 1'b0;
      pr_hit    <= 1'b0;
      pr_target <= '0;
    end else begin
      pr_valid <= lk_valid;
      pr_taken <= lk_valid && lk_dir;
      pr_hit   <= lk_valid && lk_hit;
      if (lk_valid)
        pr_target <= lk_tgt;
    end
  end
endmodule

module bhp_hybrid_chk #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              lk_valid,
  input logic [ADDR_W-1:0] lk_pc,
  input logic [DISP_W-1:0] lk_disp,
  input logic              pr_valid,
  input logic              pr_taken,
  input logic              pr_hit,
  input logic [ADDR_W-1:0] pr_target
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!pr_valid && !pr_hit && !pr_taken)); // R1

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> pr_valid); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !pr_valid |-> (!pr_hit && !pr_taken)); // R2

  AST_TARGET_SUM: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> pr_target == ($past(lk_pc)
      + {{(ADDR_W-DISP_W){$past(lk_disp[DISP_W-1])}}, $past(lk_disp)})); // R3

  AST_STATIC_RULE: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> (pr_hit || (pr_taken == $past(lk_disp[DISP_W-1])))); // R4
endmodule

bind bhp_hybrid bhp_hybrid_chk #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) chk (.*);

// File: tb/bhp_hybrid_test.sv
module bhp_hybrid_test;
  localparam int AW = 32, IW = 6, DW = 16, N = 64;

  logic clk = 0, rst = 1;
  logic lk_valid = 0, rs_valid = 0, rs_taken = 0;
  logic [AW-1:0] lk_pc = '0;
  logic [DW-1:0] lk_disp = '0;
  logic [AW-1:2] rs_pc = '0;
  logic pr_valid, pr_taken, pr_hit;
  logic [AW-1:0] pr_target;

  int tests = 0, fails = 0;
  bit m_vld [N];
  logic [AW-IW-3:0] m_tag [N];
  int m_ctr [N];

  always #5 clk = ~clk;

  bhp_hybrid #(.ADDR_W(AW), .IDX_W(IW), .DISP_W(DW)) uut (.*);

  task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk_pc(int tg, int idx);
    return AW'(tg) * 32'h100 + AW'(idx) * 4;
  endfunction

  task automatic model_resolve(logic [AW-1:0] pc, bit t);
    int i = int'(pc[IW+1:2]);
    if (m_vld[i] && m_tag[i] == pc[AW-1:IW+2]) begin
      if (t && m_ctr[i] < 3) m_ctr[i]++;
      if (!t && m_ctr[i] > 0) m_ctr[i]--;
    end else begin
      m_vld[i] = 1;
      m_tag[i] = pc[AW-1:IW+2];
      m_ctr[i] = t ? 2 : 1;
    end
  endtask

  // drives an optional resolve together with a lookup, checks one cycle later
  task automatic step(logic [AW-1:0] pc, logic [DW-1:0] d, bit do_rs,
                      logic [AW-1:0] rpc, bit t, string req);
    int i = int'(pc[IW+1:2]);
    bit hit = m_vld[i] && m_tag[i] == pc[AW-1:IW+2];
    bit dir = hit ? (m_ctr[i] >= 2) : d[DW-1];
    logic [AW-1:0] tgt = pc + AW'(int'($signed(d)));
    lk_valid = 1; lk_pc = pc; lk_disp = d;
    rs_valid = do_rs; rs_pc = rpc[AW-1:2]; rs_taken = t;
    @(negedge clk);
    lk_valid = 0; rs_valid = 0;
    if (do_rs) model_resolve(rpc, t);
    chk({req, " valid"}, AW'(pr_valid), 1);
    chk({req, " hit"}, AW'(pr_hit), AW'(hit));
    chk({req, " taken"}, AW'(pr_taken), AW'(dir));
    chk("R3 target", pr_target, tgt);
  endtask

  task automatic resolve(logic [AW-1:0] pc, bit t);
    rs_valid = 1; rs_pc = pc[AW-1:2]; rs_taken = t;
    @(negedge clk);
    rs_valid = 0;
    model_resolve(pc, t);
  endtask

  initial begin
    #2_000_000;
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] disps [6] = '{16'h8000, 16'hFFFC, 16'h0000, 16'h0004, 16'h7FFF, 16'hFF00};
    for (int i = 0; i < N; i++) m_vld[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", AW'(pr_valid), 0);
    chk("R1 reset hit", AW'(pr_hit), 0);
    rst = 0;
    @(negedge clk);
    chk("R2 idle", AW'(pr_valid), 0);

    // static rule sweep after reset (R1 R4 R5 R3)
    for (int i = 0; i < N; i++)
      for (int k = 0; k < 6; k++)
        step(mk_pc(i * 3 + k, i), disps[k], 0, '0, 0, disps[k][DW-1] ? "R4 R1" : "R5 R1");
    step(32'hFFFF_FFF0, 16'h0020, 0, '0, 0, "R5 wrap");
    @(negedge clk);
    chk("R2 gap", AW'(pr_valid), 0);

    // dynamic sweep with aliasing tags (R6 R7 R8 R9)
    for (int t = 1; t <= 3; t++)
      for (int i = 0; i < N; i++) begin
        int pat = ((i * 7) + (t * 13)) ^ 8'h5A;
        for (int s = 0; s < 6; s++) begin
          resolve(mk_pc(t, i), pat[s]);
          step(mk_pc(t, i), s[0] ? 16'h8000 : 16'h0010, 0, '0, 0, "R6 R7 R8");
        end
        if (t > 1) step(mk_pc(t - 1, i), 16'hFFF0, 0, '0, 0, "R9 old tag");
      end

    // saturation at both rails (R8)
    for (int s = 0; s < 5; s++) resolve(mk_pc(9, 5), 1);
    resolve(mk_pc(9, 5), 0);
    step(mk_pc(9, 5), 16'h0008, 0, '0, 0, "R8 top rail");
    for (int s = 0; s < 5; s++) resolve(mk_pc(9, 5), 0);
    resolve(mk_pc(9, 5), 1);
    step(mk_pc(9, 5), 16'hFFF8, 0, '0, 0, "R8 bottom rail");

    // same-cycle lookup and resolve (R10)
    step(mk_pc(20, 40), 16'hFFF0, 1, mk_pc(20, 40), 0, "R10 first");
    step(mk_pc(20, 40), 16'hFFF0, 1, mk_pc(20, 40), 1, "R10 second");
    step(mk_pc(20, 40), 16'hFFF0, 0, '0, 0, "R10 after");

    // reset again empties the table (R1)
    rst = 1; @(negedge clk); rst = 0; @(negedge clk);
    for (int i = 0; i < N; i++) m_vld[i] = 0;
    step(mk_pc(9, 5), 16'h0008, 0, '0, 0, "R1 re-reset");
    step(mk_pc(20, 40), 16'hFFF0, 0, '0, 0, "R1 re-reset");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule